// File: doc/BRIEF.md
# DC Fault Ride-Through Mode Sequencer

This block supervises a current-fed modular converter through a dc-side short circuit. It watches a dc current sample delivered once per switching period, together with the dc bus voltage and the averaged arm voltage. When the current goes over a programmable trip level, it blocks all gating at once. It then waits for the bus to collapse below a programmable safe level. After that it runs a fault-current window of programmable length in which the full-bridge cells switch bipolar and the half-bridge cells are bypassed. Finally it blocks gating again and waits until the bus has climbed back to the arm average voltage before it releases normal operation.

Every change of mode is taken on the switching-period strobe. The one exception is the trip, which takes effect on the clock edge that sees the offending sample. The outputs are a two-bit mode code, a gate-block flag and a bridge-select flag. The downstream modulators and current regulators use these to pick their behaviour. The hold window is counted in switching periods.

Top module: `fr_mode_sequencer`

## Requirements
- R1: A synchronous reset gives mode 2'b01 (output disable), gate_block 1 and fb_select 0. The block stays there until a clock edge on which period_tick is high and vbus_sample >= varm_avg; that edge gives mode 2'b00 (normal) with gate_block 0.
- R2: In mode 2'b00, a clock edge with idc_valid high and idc_sample > trip_level gives mode 2'b01 and gate_block 1 at that same edge, whether or not period_tick is high.
- R3: After a trip the mode stays 2'b01 on every tick where vbus_sample >= safe_level. At the first tick with vbus_sample < safe_level the mode is still 2'b01. The next tick after that gives mode 2'b10.
- R4: In mode 2'b10 (fault regulate), gate_block is 0 and fb_select is 1. In every other mode fb_select is 0.
- R5: Mode 2'b10 lasts for exactly hold_periods ticks, with a value of 0 treated as 1. The tick that ends it gives mode 2'b11 (post-fault disable) with gate_block 1.
- R6: In mode 2'b11 the block returns to mode 2'b00 only at a tick where vbus_sample >= varm_avg. Otherwise it stays in 2'b11.
- R7: Apart from the trip in R2, the mode changes only on an edge where period_tick is high. Current samples taken while the mode is not 2'b00 cause no change.
- R8: A sample equal to trip_level, or any sample with idc_valid low, leaves the mode at 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_tick | input | 1 | One-cycle strobe at each switching-period boundary |
| idc_valid | input | 1 | dc current sample is fresh this cycle |
| idc_sample | input | DW | dc current magnitude sample |
| vbus_sample | input | DW | dc bus voltage sample |
| varm_avg | input | DW | Arm average voltage |
| trip_level | input | DW | Current trip threshold (trip when strictly above) |
| safe_level | input | DW | Bus collapse threshold (safe when strictly below) |
| hold_periods | input | HW | Fault-current window length in switching periods |
| mode | output | 2 | 00 normal, 01 output disable, 10 fault regulate, 11 post-fault disable |
| gate_block | output | 1 | All gating inhibited |
| fb_select | output | 1 | 1: full-bridge bipolar operation with half-bridge cells bypassed |

## Verification
The bench drives a trip on a cycle with no strobe. A design that waited for the period boundary would leave gating live for up to a full switching period. It feeds a sample exactly at the trip level, and a large sample with the valid flag low. An off-by-one comparator or a missing qualifier would trip on these. It counts the one-period delay after the bus collapses and the exact number of ticks in the regulate window, with a hold of 3 and a hold of 0. A miscounted timer would show up there as a window one tick too long or too short. It also pushes large current samples and a restored bus while the strobe is low during the fault sequence, which catches a design that re-trips or leaves post-fault disable between period boundaries.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_NORMAL,
    ST_TRIP_WAIT,
    ST_TRIP_ARMED,
    ST_FAULT_REG,
    ST_POST
  } seq_state_t;

  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_BLOCK  = 2'b01;
  localparam logic [1:0] MODE_FREG   = 2'b10;
  localparam logic [1:0] MODE_POST   = 2'b11;

  function automatic logic [1:0] mode_of(seq_state_t s);
    case (s)
      ST_NORMAL:    mode_of = MODE_NORMAL;
      ST_FAULT_REG: mode_of = MODE_FREG;
      ST_POST:      mode_of = MODE_POST;
      default:      mode_of = MODE_BLOCK;
    endcase
  endfunction
endpackage

// File: rtl/fr_level_cmp.sv
module fr_level_cmp #(
  parameter int DW = 12
) (
  input  logic          idc_valid,
  input  logic [DW-1:0] idc_sample,
  input  logic [DW-1:0] vbus_sample,
  input  logic [DW-1:0] varm_avg,
  input  logic [DW-1:0] trip_level,
  input  logic [DW-1:0] safe_level,
  output logic          over_trip,
  output logic          bus_safe,
  output logic          bus_restored
);
  // Trip is strict, so a sample equal to the level does not trip.
  assign over_trip    = idc_valid && (idc_sample > trip_level);
  assign bus_safe     = vbus_sample < safe_level;
  assign bus_restored = vbus_sample >= varm_avg;
endmodule

// File: rtl/fr_hold_timer.sv
module fr_hold_timer #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          run,
  input  logic          tick,
  input  logic [HW-1:0] hold,
  output logic          expire
);
  logic [HW-1:0] cnt;
  logic [HW-1:0] last;

  // A hold of zero behaves as one period.
  assign last   = (hold == '0) ? '0 : hold - 1'b1;
  assign expire = run && tick && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= '0;
    end else if (run && tick && (cnt < last)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fr_mode_sequencer.sv
module fr_mode_sequencer #(
  parameter int DW = 12,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          period_tick,
  input  logic          idc_valid,
  input  logic [DW-1:0] idc_sample,
  input  logic [DW-1:0] vbus_sample,
  input  logic [DW-1:0] varm_avg,
  input  logic [DW-1:0] trip_level,
  input  logic [DW-1:0] safe_level,
  input  logic [HW-1:0] hold_periods,
  output logic [1:0]    mode,
  output logic          gate_block,
  output logic          fb_select
);
  import fr_pkg::*;

  seq_state_t state, nxt;
  logic over_trip, bus_safe, bus_restored;
  logic hold_load, hold_expire;

  fr_level_cmp #(.DW(DW)) u_cmp (
    .idc_valid    (idc_valid),
    .idc_sample   (idc_sample),
    .vbus_sample  (vbus_sample),
    .varm_avg     (varm_avg),
    .trip_level   (trip_level),
    .safe_level   (safe_level),
    .over_trip    (over_trip),
    .bus_safe     (bus_safe),
    .bus_restored (bus_restored)
  );

  fr_hold_timer #(.HW(HW)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load   (hold_load),
    .run    (state == ST_FAULT_REG),
    .tick   (period_tick),
    .hold   (hold_periods),
    .expire (hold_expire)
  );

  always_comb begin
    nxt       = state;
    hold_load = 1'b0;
    case (state)
      ST_START:      if (period_tick && bus_restored) nxt = ST_NORMAL;
      ST_NORMAL:     if (over_trip) nxt = ST_TRIP_WAIT;
      ST_TRIP_WAIT:  if (period_tick && bus_safe) nxt = ST_TRIP_ARMED;
      ST_TRIP_ARMED: if (period_tick) begin
                       nxt       = ST_FAULT_REG;
                       hold_load = 1'b1;
                     end
      ST_FAULT_REG:  if (hold_expire) nxt = ST_POST;
      ST_POST:       if (period_tick && bus_restored) nxt = ST_NORMAL;
      default:       nxt = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_START;
      mode       <= MODE_BLOCK;
      gate_block <= 1'b1;
      fb_select  <= 1'b0;
    end else begin
      state      <= nxt;
      mode       <= mode_of(nxt);
      gate_block <= (nxt != ST_NORMAL) && (nxt != ST_FAULT_REG);
      fb_select  <= (nxt == ST_FAULT_REG);
    end
  end

  AST_TRIP_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_NORMAL && idc_valid && idc_sample > trip_level)
      |=> (mode == MODE_BLOCK && gate_block)); // R2

  AST_NO_CHANGE_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    (!period_tick && !(mode == MODE_NORMAL && idc_valid && idc_sample > trip_level))
      |=> $stable(mode)); // R7

  AST_FB_IN_REG: assert property (@(posedge clk) disable iff (rst)
    fb_select |-> (mode == MODE_FREG && !gate_block)); // R4

  AST_REG_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(fb_select) |-> ($past(mode) == MODE_BLOCK && $past(period_tick))); // R3

  AST_POST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_POST && !(period_tick && vbus_sample >= varm_avg))
      |=> (mode == MODE_POST)); // R6
endmodule

// File: tb/tb_fr_mode_sequencer.sv
module tb_fr_mode_sequencer;
  localparam int DW = 12;
  localparam int HW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          period_tick = 1'b0;
  logic          idc_valid = 1'b0;
  logic [DW-1:0] idc_sample = '0;
  logic [DW-1:0] vbus_sample = '0;
  logic [DW-1:0] varm_avg = 12'd250;
  logic [DW-1:0] trip_level = 12'd180;
  logic [DW-1:0] safe_level = 12'd25;
  logic [HW-1:0] hold_periods = 16'd3;
  logic [1:0]    mode;
  logic          gate_block;
  logic          fb_select;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fr_mode_sequencer #(.DW(DW), .HW(HW)) dut (
    .clk(clk), .rst(rst), .period_tick(period_tick), .idc_valid(idc_valid),
    .idc_sample(idc_sample), .vbus_sample(vbus_sample), .varm_avg(varm_avg),
    .trip_level(trip_level), .safe_level(safe_level), .hold_periods(hold_periods),
    .mode(mode), .gate_block(gate_block), .fb_select(fb_select)
  );

  // One clock: inputs set beforehand, strobes cleared 2 ns after the edge.
  task automatic cyc(input bit tk);
    period_tick = tk;
    @(posedge clk);
    #2;
    period_tick = 1'b0;
    idc_valid   = 1'b0;
  endtask

  task automatic chk(input string req, input logic [1:0] em, input logic eg, input logic ef);
    checks++;
    if (mode !== em || gate_block !== eg || fb_select !== ef) begin
      fails++;
      $display("FAIL %s: mode=%b gate=%b fb=%b expected mode=%b gate=%b fb=%b",
               req, mode, gate_block, fb_select, em, eg, ef);
    end
  endtask

  task automatic t_reset_start();
    rst = 1'b1; vbus_sample = 12'd10;
    cyc(0); cyc(0);
    rst = 1'b0;
    chk("R1 reset", 2'b01, 1, 0);
    cyc(1);
    chk("R1 low bus keeps disable", 2'b01, 1, 0);
    vbus_sample = 12'd250;
    cyc(0);
    chk("R7 no start off tick", 2'b01, 1, 0);
    cyc(1);
    chk("R1 start to normal", 2'b00, 0, 0);
  endtask

  task automatic t_no_trip();
    idc_sample = 12'd180; idc_valid = 1'b1;
    cyc(0);
    chk("R8 equal level", 2'b00, 0, 0);
    idc_sample = 12'd4000; idc_valid = 1'b0;
    cyc(1);
    chk("R8 invalid sample", 2'b00, 0, 0);
  endtask

  task automatic run_fault(input logic [HW-1:0] hold, input int ticks_in_reg);
    hold_periods = hold;
    idc_sample = 12'd181; idc_valid = 1'b1;
    cyc(0);
    chk("R2 trip off tick", 2'b01, 1, 0);
    cyc(1);
    chk("R3 bus high keeps disable", 2'b01, 1, 0);
    vbus_sample = 12'd24;
    cyc(1);
    chk("R3 first safe tick", 2'b01, 1, 0);
    cyc(0);
    chk("R7 off tick in wait", 2'b01, 1, 0);
    cyc(1);
    chk("R4 enter regulate", 2'b10, 0, 1);
    for (int i = 1; i < ticks_in_reg; i++) begin
      idc_sample = 12'd4000; idc_valid = 1'b1;
      cyc(0);
      chk("R7 sample ignored in regulate", 2'b10, 0, 1);
      cyc(1);
      chk("R5 window still open", 2'b10, 0, 1);
    end
    cyc(1);
    chk("R5 window end", 2'b11, 1, 0);
    vbus_sample = 12'd250;
    cyc(0);
    chk("R7 post off tick", 2'b11, 1, 0);
    vbus_sample = 12'd249;
    cyc(1);
    chk("R6 bus below arm", 2'b11, 1, 0);
    vbus_sample = 12'd250;
    cyc(1);
    chk("R6 recover", 2'b00, 0, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset_start();
    t_no_trip();
    run_fault(16'd3, 3);
    run_fault(16'd0, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule